// File: doc/BRIEF.md
# Console Register Block

This block sits on a 16-bit word-addressed processor bus and gives software a console through five registers. Two of them track incoming keystrokes, two handle outgoing characters, and one holds a machine control word. Its top bit gates the whole processor. Incoming bytes arrive on a byte-wide strobe from the device side. Outgoing bytes leave on a byte-wide valid/ready stream. The status flags change only as side effects of bus traffic and device events.

Bus reads are combinational: `bus_rdata` reflects `bus_addr` while `bus_rd` is high. Every side effect of an access takes place at the clock edge that ends the access cycle. The block raises `mem_sel` for any address it does not own, so the bus can route that access to memory.

Back-pressure rules for the transmit stream are simple. Once `tx_valid` rises it stays high, and `tx_data` holds its value, until a cycle in which `tx_ready` is high. `tx_valid` falls at the edge that ends that cycle. The receive side has no back-pressure. A byte strobed by `rx_valid` is always accepted, and it overwrites any byte that has not been read.

Top module: `console_mmio`

## Requirements
- R1: The block claims exactly the addresses 0xFE00 (key status), 0xFE02 (key data), 0xFE04 (display status), 0xFE06 (display data) and 0xFFFE (machine control). For every other address, `mem_sel` is 1 and `bus_rdata` reads 0. For the five claimed addresses, `mem_sel` is 0.
- R2: After reset, the register values are as follows. Key status reads 0x0000, key data reads 0x0000, display status reads 0x8000 and machine control reads 0x8000. After reset `run_en` is 1 and `tx_valid` is 0.
- R3: A cycle with `rx_valid` high stores `rx_data`, zero-extended, in key data. From the next cycle, key status reads 0x8000.
- R4: A bus read of key data returns the stored byte, and from the next cycle key status reads 0x0000. A read of key status does not clear it. If `rx_valid` is high in the same cycle as a read of key data, the read returns the old byte and the flag stays set with the new byte.
- R5: A byte that arrives while key status is still set replaces key data, and key status stays 0x8000.
- R6: Status bits 14..0 always read 0, and display data reads 0. Writes to key status, key data and display status have no effect.
- R7: A write to display data while the display is idle does two things from the next cycle: display status reads 0x0000, and `tx_valid` is 1 with `tx_data` equal to bits 7..0 of the written word.
- R8: While `tx_valid` is 1 and `tx_ready` is 0, `tx_valid` stays 1 and `tx_data` holds. After a cycle with both high, `tx_valid` is 0 and display status reads 0x8000 in the next cycle.
- R9: A write to display data while `tx_valid` is 1 is ignored. `tx_data` keeps the earlier byte, and no second transfer follows.
- R10: A write to machine control stores the whole word, which reads back from the next cycle. `run_en` equals bit 15 of the stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 16 | Word address of the bus access |
| bus_rd | input | 1 | Read strobe for this cycle |
| bus_wr | input | 1 | Write strobe for this cycle |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid in the same cycle as `bus_rd` |
| mem_sel | output | 1 | High when the address is not one of the block's registers |
| rx_valid | input | 1 | Strobe marking a received byte |
| rx_data | input | 8 | Received byte |
| tx_valid | output | 1 | Transmit byte present |
| tx_ready | input | 1 | Sink accepts the byte this cycle |
| tx_data | output | 8 | Transmit byte |
| run_en | output | 1 | Processor run enable |

## Verification
An internal flag that is stuck or late shows at the ports within one cycle of the access that should have changed it. A key flag that is not cleared by a data read still reads 0x8000 on the next status read. A busy flag that does not fall leaves `tx_valid` high one cycle after the handshake. A display byte latched on the wrong edge makes `tx_data` move while `tx_ready` is low. The bench sweeps every byte value through both data paths and varies the stall length on the transmit side, so an error in a data bit or a lost flag shows in the cycle that follows.

// File: rtl/con_pkg.sv
package con_pkg;
  // Register selected by the bus address
  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_KSTAT,
    SEL_KDATA,
    SEL_DSTAT,
    SEL_DDATA,
    SEL_MCTL
  } con_sel_e;

  localparam int FLAG_BIT = 15;
endpackage

// File: rtl/con_addr_dec.sv
module con_addr_dec
  import con_pkg::*;
#(
  parameter int AW = 16,
  parameter logic [AW-1:0] KSTAT_A = 16'hFE00,
  parameter logic [AW-1:0] KDATA_A = 16'hFE02,
  parameter logic [AW-1:0] DSTAT_A = 16'hFE04,
  parameter logic [AW-1:0] DDATA_A = 16'hFE06,
  parameter logic [AW-1:0] MCTL_A  = 16'hFFFE
) (
  input  logic [AW-1:0] addr,
  output con_sel_e      sel,
  output logic          hit
);
  always_comb begin
    unique case (addr)
      KSTAT_A: sel = SEL_KSTAT;
      KDATA_A: sel = SEL_KDATA;
      DSTAT_A: sel = SEL_DSTAT;
      DDATA_A: sel = SEL_DDATA;
      MCTL_A:  sel = SEL_MCTL;
      default: sel = SEL_NONE;
    endcase
  end

  assign hit = (sel != SEL_NONE);
endmodule

// File: rtl/con_kbd.sv
module con_kbd #(
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_valid,
  input  logic [BW-1:0] rx_data,
  input  logic          data_rd,
  output logic          ready,
  output logic [BW-1:0] data
);
  // An arriving byte wins over a clearing read in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready <= 1'b0;
      data  <= '0;
    end else if (rx_valid) begin
      ready <= 1'b1;
      data  <= rx_data;
    end else if (data_rd) begin
      ready <= 1'b0;
    end
  end
endmodule

// File: rtl/con_disp.sv
module con_disp #(
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [BW-1:0] wbyte,
  input  logic          tx_ready,
  output logic          tx_valid,
  output logic [BW-1:0] tx_data,
  output logic          ready
);
  logic          busy;
  logic [BW-1:0] held;

  // A write while busy is dropped so the presented byte stays stable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      held <= '0;
    end else if (busy) begin
      if (tx_ready) busy <= 1'b0;
    end else if (wr) begin
      busy <= 1'b1;
      held <= wbyte;
    end
  end

  assign tx_valid = busy;
  assign tx_data  = held;
  assign ready    = ~busy;
endmodule

// File: rtl/con_mctl.sv
module con_mctl #(
  parameter int DW = 16,
  parameter logic [DW-1:0] RST_VAL = 16'h8000,
  parameter int RUN_BIT = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] word,
  output logic          run_en
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  word <= RST_VAL;
    else if (wr) word <= wdata;
  end

  assign run_en = word[RUN_BIT];
endmodule

// File: rtl/console_mmio.sv
module console_mmio
  import con_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int BW = 8,
  parameter logic [AW-1:0] KSTAT_A = 16'hFE00,
  parameter logic [AW-1:0] KDATA_A = 16'hFE02,
  parameter logic [AW-1:0] DSTAT_A = 16'hFE04,
  parameter logic [AW-1:0] DDATA_A = 16'hFE06,
  parameter logic [AW-1:0] MCTL_A  = 16'hFFFE
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_rd,
  input  logic          bus_wr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          mem_sel,
  input  logic          rx_valid,
  input  logic [BW-1:0] rx_data,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic [BW-1:0] tx_data,
  output logic          run_en
);
  localparam int PAD_W = DW - BW;
  localparam logic [DW-1:0] MCTL_RST = DW'(1) << FLAG_BIT;

  con_sel_e      sel;
  logic          hit;
  logic          kbd_rdy;
  logic [BW-1:0] kbd_byte;
  logic          disp_rdy;
  logic [DW-1:0] mctl_word;

  con_addr_dec #(
    .AW(AW), .KSTAT_A(KSTAT_A), .KDATA_A(KDATA_A),
    .DSTAT_A(DSTAT_A), .DDATA_A(DDATA_A), .MCTL_A(MCTL_A)
  ) u_dec (
    .addr(bus_addr), .sel(sel), .hit(hit)
  );

  con_kbd #(.BW(BW)) u_kbd (
    .clk(clk), .rst_n(rst_n),
    .rx_valid(rx_valid), .rx_data(rx_data),
    .data_rd(bus_rd && sel == SEL_KDATA),
    .ready(kbd_rdy), .data(kbd_byte)
  );

  con_disp #(.BW(BW)) u_disp (
    .clk(clk), .rst_n(rst_n),
    .wr(bus_wr && sel == SEL_DDATA),
    .wbyte(bus_wdata[BW-1:0]),
    .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_data(tx_data),
    .ready(disp_rdy)
  );

  con_mctl #(.DW(DW), .RST_VAL(MCTL_RST), .RUN_BIT(FLAG_BIT)) u_mctl (
    .clk(clk), .rst_n(rst_n),
    .wr(bus_wr && sel == SEL_MCTL),
    .wdata(bus_wdata),
    .word(mctl_word), .run_en(run_en)
  );

  logic [DW-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    case (sel)
      SEL_KSTAT: rd_mux[FLAG_BIT] = kbd_rdy;
      SEL_KDATA: rd_mux = {{PAD_W{1'b0}}, kbd_byte};
      SEL_DSTAT: rd_mux[FLAG_BIT] = disp_rdy;
      SEL_MCTL:  rd_mux = mctl_word;
      default:   rd_mux = '0;
    endcase
  end

  assign bus_rdata = bus_rd ? rd_mux : '0;
  assign mem_sel   = ~hit;
endmodule

// File: rtl/con_mmio_chk.sv
module con_mmio_chk #(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int BW = 8,
  parameter logic [AW-1:0] KDATA_A = 16'hFE02,
  parameter logic [AW-1:0] DDATA_A = 16'hFE06,
  parameter logic [AW-1:0] MCTL_A  = 16'hFFFE
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] bus_addr,
  input logic          bus_rd,
  input logic          bus_wr,
  input logic [DW-1:0] bus_wdata,
  input logic [DW-1:0] bus_rdata,
  input logic          mem_sel,
  input logic          rx_valid,
  input logic          tx_valid,
  input logic          tx_ready,
  input logic [BW-1:0] tx_data,
  input logic          run_en,
  input logic          kbd_rdy
);
  assert_unclaimed_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_sel |-> bus_rdata == '0);

  assert_rx_sets_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> kbd_rdy);

  assert_read_clears_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == KDATA_A && !rx_valid) |=> !kbd_rdy);

  assert_launch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == DDATA_A && !tx_valid)
      |=> tx_valid && tx_data == $past(bus_wdata[BW-1:0]));

  assert_hold_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> tx_valid && $stable(tx_data));

  assert_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !tx_valid);

  assert_run_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == MCTL_A) |=> run_en == $past(bus_wdata[15]));

  assert_run_steady_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr == MCTL_A) |=> $stable(run_en));
endmodule

bind console_mmio con_mmio_chk #(
  .AW(AW), .DW(DW), .BW(BW),
  .KDATA_A(KDATA_A), .DDATA_A(DDATA_A), .MCTL_A(MCTL_A)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
  .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .mem_sel(mem_sel), .rx_valid(rx_valid), .tx_valid(tx_valid),
  .tx_ready(tx_ready), .tx_data(tx_data), .run_en(run_en),
  .kbd_rdy(kbd_rdy)
);

// File: tb/tb_console_mmio.sv
module tb_console_mmio;
  localparam logic [15:0] A_KS = 16'hFE00, A_KD = 16'hFE02, A_DS = 16'hFE04,
                          A_DD = 16'hFE06, A_MC = 16'hFFFE;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [15:0] bus_addr = '0, bus_wdata = '0;
  logic bus_rd = 1'b0, bus_wr = 1'b0;
  logic [15:0] bus_rdata;
  logic mem_sel, rx_valid = 1'b0, tx_valid, tx_ready = 1'b0, run_en;
  logic [7:0] rx_data = '0, tx_data;

  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  console_mmio dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .mem_sel(mem_sel), .rx_valid(rx_valid), .rx_data(rx_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .run_en(run_en)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Each task starts just after a falling edge and ends at the next one
  task automatic rd(input logic [15:0] a, output logic [15:0] d);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic wr(input logic [15:0] a, input logic [15:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rx(input logic [7:0] b);
    rx_data = b; rx_valid = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  function automatic logic [15:0] model_map(input logic [15:0] a);
    case (a)
      A_KS: return 16'h0000;
      A_KD: return 16'h0000;
      A_DS: return 16'h8000;
      A_DD: return 16'h0000;
      A_MC: return 16'h8000;
      default: return 16'h0000;
    endcase
  endfunction

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 reset state
    chk("R2 run_en", {15'd0, run_en}, 16'd1);
    chk("R2 tx_valid", {15'd0, tx_valid}, 16'd0);
    rd(A_KS, v); chk("R2 key status", v, 16'h0000);
    rd(A_KD, v); chk("R2 key data", v, 16'h0000);
    rd(A_DS, v); chk("R2 display status", v, 16'h8000);
    rd(A_MC, v); chk("R2 machine control", v, 16'h8000);

    // R1 address sweep near both register groups, plus scattered addresses
    for (int i = 0; i < 32; i++) begin
      logic [15:0] a;
      logic claimed;
      a = (i < 16) ? 16'hFE00 + 16'(i) : 16'hFFF0 + 16'(i - 16);
      claimed = (a == A_KS || a == A_KD || a == A_DS || a == A_DD || a == A_MC);
      rd(a, v);
      chk("R1 mem_sel", {15'd0, mem_sel}, {15'd0, !claimed});
      chk("R1 read value", v, model_map(a));
    end
    for (int i = 0; i < 16; i++) begin
      rd(16'(i * 16'h0FF3), v);
      chk("R1 far mem_sel", {15'd0, mem_sel}, 16'd1);
      chk("R1 far read", v, 16'h0000);
    end

    // R3 and R4 over every byte value
    for (int b = 0; b < 256; b++) begin
      rx(8'(b));
      rd(A_KS, v); chk("R3 flag set", v, 16'h8000);
      rd(A_KS, v); chk("R4 status read keeps flag", v, 16'h8000);
      rd(A_KD, v); chk("R3 zero-extended byte", v, 16'(b));
      rd(A_KS, v); chk("R4 flag cleared", v, 16'h0000);
    end

    // R5 overwrite while ready
    rx(8'h41); rx(8'hC7);
    rd(A_KS, v); chk("R5 flag stays", v, 16'h8000);
    rd(A_KD, v); chk("R5 newest byte", v, 16'h00C7);

    // R4 arrival in the same cycle as a data read
    rx(8'h12);
    rx_data = 8'h9E; rx_valid = 1'b1;
    rd(A_KD, v); rx_valid = 1'b0;
    chk("R4 old byte returned", v, 16'h0012);
    rd(A_KS, v); chk("R4 flag kept by arrival", v, 16'h8000);
    rd(A_KD, v); chk("R4 new byte stored", v, 16'h009E);

    // R6 writes to status and key data ignored
    wr(A_KS, 16'hFFFF); rd(A_KS, v); chk("R6 key status write ignored", v, 16'h0000);
    rx(8'h5A);
    wr(A_KD, 16'h00FF); wr(A_KS, 16'h0000);
    rd(A_KS, v); chk("R6 key status kept", v, 16'h8000);
    rd(A_KD, v); chk("R6 key data write ignored", v, 16'h005A);
    wr(A_DS, 16'h0000); rd(A_DS, v); chk("R6 display status write ignored", v, 16'h8000);
    chk("R6 no transfer", {15'd0, tx_valid}, 16'd0);
    rd(A_DD, v); chk("R6 display data reads zero", v, 16'h0000);

    // R7, R8, R9 over every byte value, stall of 0..3 cycles
    for (int b = 0; b < 256; b++) begin
      int d;
      logic [7:0] eb;
      d = b % 4;
      eb = 8'(b);
      wr(A_DD, {8'hA5 ^ eb, eb});
      chk("R7 valid raised", {15'd0, tx_valid}, 16'd1);
      chk("R7 low byte", {8'd0, tx_data}, {8'd0, eb});
      rd(A_DS, v); chk("R7 display busy", v, 16'h0000);
      if (b % 8 == 3) begin
        wr(A_DD, {8'h00, ~eb});
        chk("R9 byte held", {8'd0, tx_data}, {8'd0, eb});
      end
      for (int k = 0; k < d; k++) begin
        #1;
        chk("R8 valid held", {15'd0, tx_valid}, 16'd1);
        chk("R8 data held", {8'd0, tx_data}, {8'd0, eb});
        @(negedge clk);
      end
      tx_ready = 1'b1;
      #1 chk("R8 data at handshake", {8'd0, tx_data}, {8'd0, eb});
      @(negedge clk);
      tx_ready = 1'b0;
      #1 chk("R8 valid dropped", {15'd0, tx_valid}, 16'd0);
      rd(A_DS, v); chk("R8 display ready again", v, 16'h8000);
      chk("R9 no second transfer", {15'd0, tx_valid}, 16'd0);
    end

    // R10 machine control patterns
    for (int i = 0; i < 16; i++) begin
      logic [15:0] w;
      w = 16'(i * 16'h1111) ^ ((i % 2 == 1) ? 16'h8000 : 16'h0000);
      wr(A_MC, w);
      chk("R10 run_en", {15'd0, run_en}, {15'd0, w[15]});
      rd(A_MC, v); chk("R10 readback", v, w);
    end
    wr(A_MC, 16'h8000);
    chk("R10 run restored", {15'd0, run_en}, 16'd1);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule